// File: doc/BRIEF.md
# DRAM Initialization and Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM. It drives the active-low row strobe `ras_n`, the active-low column strobe `cas_n` and a row address. After reset it waits out the power-up pause. It then issues eight wake-up cycles and raises `ready`. From then on it keeps the array refreshed: one row refresh per refresh period, issued through a request/grant handshake with the host access arbiter. The block drives the strobes only during its own cycles.

The host can put the memory into self-refresh and take it out again. Two static inputs select the refresh style. `ref_cbr` chooses between refresh that uses the memory's internal counter (strobe-order refresh) and refresh that uses the row counter inside this block (row-strobe-only refresh, with the address driven). `ref_burst` marks whether the system refreshes all rows in bursts rather than spread evenly. The style decides how the wake-up cycles are issued. It also decides how much refresh brackets self-refresh: a single cycle after exit for evenly spread strobe-order refresh, and a full pass over every row before entry and after exit for any other style.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is low, and for the first PAUSE_CYC clock cycles after it is released, `ras_n` and `cas_n` stay high (1) and `ready` and `bus_req` stay low.
- R2: After the pause, exactly WAKE_CNT (8) wake-up cycles are issued. They are strobe-order cycles when `ref_cbr`=1 and row-strobe-only cycles when `ref_cbr`=0. `ready` rises only after the last one has finished, and it never falls again until reset.
- R3: `row_addr` does not change while `ras_n` is low. A row-strobe-only cycle (`cas_n` high when `ras_n` falls) drives the internal row counter. That counter starts at 0 after reset, advances by one per row-strobe-only cycle and wraps after ROWS-1.
- R4: In a strobe-order cycle, `cas_n` is low for exactly T_CSR cycles before `ras_n` falls. Every refresh cycle holds `ras_n` low for exactly T_RAS cycles. `ras_n` is high for at least T_RP cycles before any fall.
- R5: Once `ready` is high, a refresh is owed once per REF_PERIOD cycles. For each owed refresh the block raises `bus_req`, drives no strobe low until `bus_gnt` is high, and issues one refresh cycle. Refreshes owed while the grant is withheld are counted and all issued later.
- R6: A one-cycle pulse on `sr_enter` is remembered. The block then takes the bus and drives `cas_n` low, and T_CSR cycles later `ras_n` low. Both strobes stay low until `sr_exit` is high and `ras_n` has been low for at least T_RAS cycles. With `ref_cbr`=1 and `ref_burst`=0, no refresh cycle comes before this entry.
- R7: On exit, both strobes are high for T_RP cycles. With `ref_cbr`=1 and `ref_burst`=0, exactly one strobe-order cycle follows, and then `bus_req` falls.
- R8: With any other style (`ref_cbr`=0 or `ref_burst`=1), exactly ROWS refresh cycles of the selected kind are issued just before the self-refresh entry. Another ROWS are issued after the exit precharge, before `bus_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_cbr | input | 1 | 1: strobe-order refresh using the memory's counter; 0: row-strobe-only refresh with driven address |
| ref_burst | input | 1 | 1: system refreshes in bursts; 0: spread evenly |
| sr_enter | input | 1 | Pulse to request self-refresh entry |
| sr_exit | input | 1 | Level to request self-refresh exit |
| bus_gnt | input | 1 | Arbiter grant, held while `bus_req` is high |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| row_addr | output | ROW_W | Row address for row-strobe-only cycles |
| ready | output | 1 | Initialization finished |
| bus_req | output | 1 | Bus request toward the host arbiter |

## Verification
The strobes are registered from the next-state decode. The first strobe can therefore go low no earlier than PAUSE_CYC cycles after reset release, and each strobe phase lasts exactly its parameter count. The bench monitors the strobes at the falling clock edge and measures every low and high run directly, so it needs no latency model. Counts of wake-up, burst and post-exit cycles are taken when `ready` rises, when self-refresh is detected and when `bus_req` falls. Each of those is the first sample after the last pulse's precharge. For the periodic-refresh count, the one refresh that may still be owed but not yet started at the sample is allowed as a tolerance of one period.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC  = 25000,
  parameter int ROWS       = 4096,
  parameter int REF_PERIOD = 3900,
  parameter int WAKE_CNT   = 8,
  parameter int T_RAS      = 12,
  parameter int T_RP       = 10,
  parameter int T_CSR      = 3,
  parameter int PEND_W     = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_cbr,
  input  logic             ref_burst,
  input  logic             sr_enter,
  input  logic             sr_exit,
  input  logic             bus_gnt,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             ready,
  output logic             bus_req
);
  localparam int L1   = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int L2   = (L1 > T_CSR) ? L1 : T_CSR;
  localparam int MAXL = (PAUSE_CYC > L2) ? PAUSE_CYC : L2;
  localparam int TW   = $clog2(MAXL + 1);
  localparam int CW   = $clog2(((ROWS > WAKE_CNT) ? ROWS : WAKE_CNT) + 1);
  localparam int IW   = $clog2(REF_PERIOD + 1);

  typedef enum logic [3:0] {
    S_PAUSE, S_IDLE, S_GNT, S_CSR, S_RAS, S_RP, S_SCSR, S_SHOLD, S_SRP
  } st_t;
  typedef enum logic [1:0] {OP_INIT, OP_REF, OP_PRE, OP_POST} op_t;

  st_t st, nst, first_st;
  op_t op, nop;
  logic [TW-1:0]     tmr;
  logic [CW-1:0]     left, nleft;
  logic [PEND_W-1:0] pend;
  logic [IW-1:0]     itmr;
  logic [ROW_W-1:0]  rc;
  logic cyc_cbr, ncbr, sr_want, direct, tick, done, fin, inc, dec;
  int   len;

  assign direct   = ref_cbr && !ref_burst;
  assign first_st = ref_cbr ? S_CSR : S_RAS;
  assign tick     = ready && (int'(itmr) == REF_PERIOD - 1);
  assign done     = int'(tmr) >= len - 1;
  assign fin      = (st == S_RP) && done && (left <= CW'(1));
  assign dec      = fin && (op == OP_REF);
  assign inc      = tick && ((pend != '1) || dec);
  assign bus_req  = (st != S_PAUSE) && (st != S_IDLE) && (op != OP_INIT);
  assign row_addr = rc;

  always_comb begin
    case (st)
      S_PAUSE:         len = PAUSE_CYC;
      S_CSR, S_SCSR:   len = T_CSR;
      S_RAS, S_SHOLD:  len = T_RAS;
      S_RP, S_SRP:     len = T_RP;
      default:         len = 1;
    endcase
  end

  always_comb begin
    nst = st; nop = op; nleft = left; ncbr = cyc_cbr;
    case (st)
      S_PAUSE: if (done) begin
        nst = first_st; nop = OP_INIT; nleft = CW'(WAKE_CNT); ncbr = ref_cbr;
      end
      S_IDLE: if (sr_enter || sr_want) begin
        nst = S_GNT; nop = OP_PRE; nleft = direct ? '0 : CW'(ROWS);
      end else if (pend != '0) begin
        nst = S_GNT; nop = OP_REF; nleft = CW'(1);
      end
      S_GNT: if (bus_gnt) begin
        if (left == '0) nst = S_SCSR;
        else begin nst = first_st; ncbr = ref_cbr; end
      end
      S_CSR: if (done) nst = S_RAS;
      S_RAS: if (done) nst = S_RP;
      S_RP: if (done) begin
        if (left > CW'(1)) begin
          nleft = left - 1'b1; nst = first_st; ncbr = ref_cbr;
        end else begin
          nleft = '0;
          nst = (op == OP_PRE) ? S_SCSR : S_IDLE;
        end
      end
      S_SCSR:  if (done) nst = S_SHOLD;
      S_SHOLD: if (done && sr_exit) nst = S_SRP;
      S_SRP: if (done) begin
        nst = first_st; ncbr = ref_cbr; nop = OP_POST;
        nleft = direct ? CW'(1) : CW'(ROWS);
      end
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PAUSE; op <= OP_INIT; left <= '0; cyc_cbr <= 1'b0;
      tmr <= '0; pend <= '0; itmr <= '0; rc <= '0; sr_want <= 1'b0;
      ready <= 1'b0; ras_n <= 1'b1; cas_n <= 1'b1;
    end else begin
      st <= nst; op <= nop; left <= nleft; cyc_cbr <= ncbr;
      if (nst != st) tmr <= '0;
      else if (!(st == S_SHOLD && done)) tmr <= tmr + 1'b1;
      ras_n <= !(nst == S_RAS || nst == S_SHOLD);
      cas_n <= !(nst == S_CSR || nst == S_SCSR || nst == S_SHOLD || (nst == S_RAS && ncbr));
      if (fin && op == OP_INIT) ready <= 1'b1;
      sr_want <= (sr_want || sr_enter) && (nst != S_SCSR);
      if (st == S_RAS && done && !cyc_cbr) rc <= (int'(rc) == ROWS - 1) ? '0 : rc + 1'b1;
      if (!ready || tick) itmr <= '0;
      else itmr <= itmr + 1'b1;
      if (fin && op == OP_POST) pend <= '0;
      else if (inc && !dec) pend <= pend + 1'b1;
      else if (dec && !inc) pend <= pend - 1'b1;
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int PAUSE_CYC = 25000,
  parameter int T_RAS     = 12,
  parameter int T_RP      = 10,
  parameter int ROW_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             ready,
  input logic             bus_req,
  input logic             bus_gnt
);
  int pcnt, hrun, lrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= 0; hrun <= 0; lrun <= 0;
    end else begin
      if (pcnt < PAUSE_CYC) pcnt <= pcnt + 1;
      if (ras_n) begin
        lrun <= 0;
        if (hrun < T_RP) hrun <= hrun + 1;
      end else begin
        hrun <= 0;
        if (lrun < T_RAS) lrun <= lrun + 1;
      end
    end
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt < PAUSE_CYC) |-> (ras_n && cas_n && !ready && !bus_req));
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> ready);
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n)) |-> (row_addr == $past(row_addr)));
  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));
  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hrun >= T_RP));
  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lrun >= T_RAS));
  assert_owned_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (!ras_n || !cas_n)) |-> (bus_req && bus_gnt));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PAUSE_CYC(PAUSE_CYC), .T_RAS(T_RAS), .T_RP(T_RP), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
  .ready(ready), .bus_req(bus_req), .bus_gnt(bus_gnt)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int PAUSE = 50, ROWS = 8, PER = 60, WAKE = 8;
  localparam int TRAS = 4, TRP = 3, TCSR = 2, RW = 3;

  logic clk = 0, rst_n = 0, ref_cbr = 0, ref_burst = 0, sr_enter = 0, sr_exit = 0, bus_gnt = 0;
  logic ras_n, cas_n, ready, bus_req;
  logic [RW-1:0] row_addr;
  int checks = 0, fails = 0, total = 0;
  logic hold_gnt = 0;
  int gdly = 0;

  dram_refresh_seq #(.PAUSE_CYC(PAUSE), .ROWS(ROWS), .REF_PERIOD(PER), .WAKE_CNT(WAKE),
    .T_RAS(TRAS), .T_RP(TRP), .T_CSR(TCSR), .PEND_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .ref_cbr(ref_cbr), .ref_burst(ref_burst), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .bus_gnt(bus_gnt), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
    .ready(ready), .bus_req(bus_req));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pre(input bit cbr, input bit burst);
    return (cbr && !burst) ? 0 : ROWS;
  endfunction
  function automatic int exp_post(input bit cbr, input bit burst);
    return (cbr && !burst) ? 1 : ROWS;
  endfunction

  // arbiter model: random grant delay, grant held while requested
  always @(negedge clk) begin
    total++;
    if (!rst_n || !bus_req) begin
      bus_gnt = 0; gdly = $urandom % 6;
    end else if (!bus_gnt && !hold_gnt) begin
      if (gdly == 0) bus_gnt = 1; else gdly--;
    end
  end

  // strobe monitor
  int cyc, first_s, lrun, hrun, csr, n_cbr, n_ror, n_sr, exp_row, addr_at_fall;
  bit pr, cur_cbr, in_sr, addr_bad;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; first_s = -1; lrun = 0; hrun = 0; csr = 0; n_cbr = 0; n_ror = 0; n_sr = 0;
      exp_row = 0; pr = 1; in_sr = 0; addr_bad = 0; cur_cbr = 0; addr_at_fall = 0;
    end else begin
      cyc++;
      if ((!ras_n || !cas_n) && first_s < 0) first_s = cyc;
      if (ready && (!ras_n || !cas_n)) chk(bus_gnt, "R5 strobe low without grant", bus_gnt, 1);
      if (pr && !ras_n) begin
        chk(hrun >= TRP, "R4 precharge before fall", hrun, TRP);
        cur_cbr = !cas_n; addr_bad = 0; addr_at_fall = int'(row_addr);
        if (cur_cbr) chk(csr == TCSR, "R4 cas setup before ras", csr, TCSR);
        else begin
          chk(int'(row_addr) == exp_row, "R3 row-only address", int'(row_addr), exp_row);
          exp_row = (exp_row + 1) % ROWS;
        end
      end
      if (!pr && !ras_n && int'(row_addr) != addr_at_fall) addr_bad = 1;
      if (!pr && ras_n) begin
        chk(!addr_bad, "R3 address stable while ras low", addr_bad, 0);
        if (lrun > TRAS + 1 && cur_cbr) n_sr++;
        else begin
          chk(lrun == TRAS, "R4 ras low width", lrun, TRAS);
          if (cur_cbr) n_cbr++; else n_ror++;
        end
        in_sr = 0;
      end
      if (ras_n) begin
        lrun = 0; hrun++;
        csr = cas_n ? 0 : csr + 1;
      end else begin
        hrun = 0; csr = 0; lrun++;
        if (lrun > TRAS + 1) in_sr = 1;
      end
      pr = ras_n;
    end
  end

  task automatic wait_low_req();
    for (int i = 0; i < 5000 && bus_req; i++) @(negedge clk);
    chk(!bus_req, "R7 bus_req release", bus_req, 0);
  endtask

  task automatic run_style(input bit cbr, input bit burst);
    int ready_cyc, base, e, n0, n1, c0, hold;
    @(negedge clk);
    rst_n = 0; ref_cbr = cbr; ref_burst = burst;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !ready && !bus_req, "R1 reset state", {ras_n, cas_n, ready, bus_req}, 4'b1100);
    rst_n = 1;
    for (int i = 0; i < 3000 && !ready; i++) @(negedge clk);
    chk(first_s >= PAUSE, "R1 pause before first strobe", first_s, PAUSE);
    chk((cbr ? n_cbr : n_ror) == WAKE && (n_cbr + n_ror) == WAKE, "R2 wake cycles at ready",
        n_cbr + n_ror, WAKE);
    ready_cyc = cyc; base = n_cbr + n_ror;
    repeat (150 + $urandom % 50) @(negedge clk);
    hold_gnt = 1;
    repeat (200) @(negedge clk);
    hold_gnt = 0;
    repeat (250) @(negedge clk);
    wait_low_req();
    e = (cyc - ready_cyc) / PER;
    chk((n_cbr + n_ror - base) >= e - 1 && (n_cbr + n_ror - base) <= e + 1,
        "R5 owed refreshes all issued", n_cbr + n_ror - base, e);
    chk(ready, "R2 ready stays high", ready, 1);
    n0 = n_cbr + n_ror;
    sr_enter = 1;
    @(negedge clk);
    sr_enter = 0;
    for (int i = 0; i < 5000 && !in_sr; i++) @(negedge clk);
    chk(in_sr, "R6 self-refresh entered", in_sr, 1);
    chk((n_cbr + n_ror - n0) == exp_pre(cbr, burst), burst || !cbr ? "R8 burst before entry" :
        "R6 no refresh before entry", n_cbr + n_ror - n0, exp_pre(cbr, burst));
    hold = 10 + $urandom % 40;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == hold - 1) chk(!ras_n && !cas_n, "R6 strobes held low", {ras_n, cas_n}, 0);
    end
    sr_exit = 1;
    for (int i = 0; i < 100 && !ras_n; i++) @(negedge clk);
    sr_exit = 0;
    n1 = n_cbr + n_ror; c0 = n_cbr;
    for (int i = 0; i < TRP; i++) begin
      chk(ras_n && cas_n, "R7 exit precharge", {ras_n, cas_n}, 3);
      @(negedge clk);
    end
    wait_low_req();
    chk(n_sr == 1, "R6 single self-refresh pulse", n_sr, 1);
    chk((n_cbr + n_ror - n1) == exp_post(cbr, burst), burst || !cbr ? "R8 burst after exit" :
        "R7 one cycle after exit", n_cbr + n_ror - n1, exp_post(cbr, burst));
    chk((n_cbr - c0) == (cbr ? exp_post(cbr, burst) : 0), "R7 post-exit cycle kind",
        n_cbr - c0, cbr ? exp_post(cbr, burst) : 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    run_style(1, 0);
    run_style(0, 0);
    run_style(1, 1);
    run_style(0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (total >= 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule